// File: doc/BRIEF.md
# PHY Management Register File

This block holds the 16-bit management registers of a 10/100 Ethernet PHY behind a simple parallel request port. The port carries a 5-bit PHY address and a 5-bit register address, and a request is either a write or a read. The block answers only its own PHY address. It keeps the control, status, identifier, advertisement, expansion and interrupt control/status registers. It drives the operating-mode controls, one-cycle strobes for a soft reset and for restarting auto-negotiation, and a level interrupt line.

Raw condition inputs from the rest of the PHY feed the latching status bits and the interrupt event flags. These inputs are link, jabber, remote fault, receive error, auto-negotiation complete, page received, parallel detection fault and link partner acknowledge. Reading a register that holds latched bits clears them. An event that arrives in the same cycle as that read is kept for the next read. Serial management framing, the negotiation arbitration itself and the analog front end live elsewhere.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: Only requests whose PHY address equals 00001 act. A request to any other PHY address produces no read response and changes no register.
- R2: A read returns its data on `mgmt_rdata`, with `mgmt_rvalid` high, in the cycle after the request. Register addresses 0, 1, 2, 3, 4, 6 and 17 are implemented. Every other address reads 0x0000.
- R3: Register 0 (control) resets to 0x3100. Bits 14 (loopback), 13 (speed 100), 12 (auto-negotiation enable), 11 (power down), 8 (full duplex) and 7 (collision test) are writable. Writing 1 to bit 9 raises `aneg_restart` for one cycle. Bit 9 always reads 0.
- R4: Writing 1 to bit 15 of register 0 returns every register to its reset value at that clock edge and raises `phy_rst_pulse` for one cycle. Bit 15 always reads 0.
- R5: While the auto-negotiation enable bit is 1 before a write, that write leaves the speed bit (13) and duplex bit (8) unchanged. While the enable bit is 0, the write sets them.
- R6: Register 2 reads 0x000E and register 3 reads 0x7237. Register 4 (advertisement) resets to 0x01E1. Only bits 13, 11, 10 and 8:5 of register 4 are writable, and bits 4:0 stay 00001.
- R7: Register 1 (status) reads ability bits 0x7800 ORed with: bit 5 = auto-negotiation complete input, bit 3 = auto-negotiation enable, bit 0 = 1. Bit 2 is the link bit and latches low. It is 0 after reset. Once the link input is 0 in any cycle, bit 2 reads 0 until register 1 is read. After a read it follows the link input again.
- R8: Register 1 bit 1 (jabber) and bit 4 (remote fault) latch high. Each is set by a high input and cleared only by a read of register 1.
- R9: Register 6 (expansion) bit 4 (parallel detection fault) and bit 1 (page received) latch high and clear on a read of register 6. Its other bits read 0.
- R10: Register 17 bits 7:0 are event flags that clear on a read of register 17. The flags are, in bit order:
  - 7: jabber rising edge
  - 6: receive error rising edge
  - 5: page received
  - 4: parallel detection fault
  - 3: link partner acknowledge
  - 2: any change of link
  - 1: remote fault rising edge
  - 0: auto-negotiation complete rising edge

  Bits 15:8 are writable enables. Writes do not change the flags.
- R11: `irq` is 1 exactly when some flag in register 17 and the enable 8 positions above it are both 1.
- R12: A latching event in the same cycle as a read of its register is not in the returned data. It stays latched and appears in the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mgmt_req | input | 1 | Management request valid for one cycle |
| mgmt_we | input | 1 | 1 = write, 0 = read |
| mgmt_phy_addr | input | 5 | Target PHY address |
| mgmt_reg_addr | input | 5 | Target register address |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rvalid | output | 1 | Read data valid |
| mgmt_rdata | output | 16 | Read data |
| link_up | input | 1 | Raw link status |
| jabber | input | 1 | Raw jabber condition |
| rem_fault | input | 1 | Raw remote fault condition |
| rx_err | input | 1 | Receive error level |
| aneg_complete | input | 1 | Auto-negotiation complete level |
| page_rcvd | input | 1 | Page received event |
| par_fault | input | 1 | Parallel detection fault event |
| lp_ack | input | 1 | Link partner acknowledge event |
| ctl_loopback | output | 1 | Loopback control |
| ctl_speed_100 | output | 1 | Speed selection bit (1 = 100 Mb/s) |
| ctl_aneg_en | output | 1 | Auto-negotiation enable |
| ctl_power_down | output | 1 | Power-down control |
| ctl_full_duplex | output | 1 | Duplex selection bit |
| ctl_coll_test | output | 1 | Collision test control |
| aneg_restart | output | 1 | One-cycle restart strobe |
| phy_rst_pulse | output | 1 | One-cycle soft reset strobe |
| irq | output | 1 | Interrupt line |

## Verification
The assertions take for granted that the request fields are stable and known in any cycle where `mgmt_req` is high. They also assume `rst_n` is held low across the first clock edges, so that every `$past` term refers to reset-time values. The stimulus meets both conditions. It changes every input only on the falling clock edge, holds reset for several cycles, and issues each management request for exactly one cycle. Condition inputs are raised as one-cycle pulses or held levels. Some are timed to land on the same cycle as a read, to exercise the event-during-read case.

// File: rtl/phy_mgmt_pkg.sv
// Shared constants and types for the PHY management register file.
// Assumes 16-bit registers and 5-bit addressing, as in the serial management frame.
package phy_mgmt_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 5;
    localparam int EV_N   = 8;

    localparam logic [ADDR_W-1:0] REG_CTRL = 5'd0;
    localparam logic [ADDR_W-1:0] REG_STAT = 5'd1;
    localparam logic [ADDR_W-1:0] REG_ID1  = 5'd2;
    localparam logic [ADDR_W-1:0] REG_ID2  = 5'd3;
    localparam logic [ADDR_W-1:0] REG_ADV  = 5'd4;
    localparam logic [ADDR_W-1:0] REG_EXP  = 5'd6;
    localparam logic [ADDR_W-1:0] REG_IRQ  = 5'd17;

    localparam logic [DATA_W-1:0] ID1_VAL   = 16'h000E;
    localparam logic [DATA_W-1:0] ID2_VAL   = 16'h7237;
    localparam logic [DATA_W-1:0] ADV_RST   = 16'h01E1;
    localparam logic [DATA_W-1:0] ADV_WMASK = 16'h2DE0;
    localparam logic [DATA_W-1:0] ABILITY   = 16'h7800;

    // Bit positions inside the control register.
    localparam int CB_RESET   = 15;
    localparam int CB_LOOP    = 14;
    localparam int CB_SPEED   = 13;
    localparam int CB_ANEG    = 12;
    localparam int CB_PWRDN   = 11;
    localparam int CB_RESTART = 9;
    localparam int CB_DUPLEX  = 8;
    localparam int CB_COLT    = 7;

    // Operating-mode fields held in the control register.
    typedef struct packed {
        logic loopback;
        logic speed_100;
        logic aneg_en;
        logic power_down;
        logic full_duplex;
        logic coll_test;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{loopback: 1'b0, speed_100: 1'b1, aneg_en: 1'b1,
                                   power_down: 1'b0, full_duplex: 1'b1, coll_test: 1'b0};

    // Latched status bits, indices into one latch vector.
    localparam int LB_LINK = 0;
    localparam int LB_JAB  = 1;
    localparam int LB_RF   = 2;
    localparam int LB_PDF  = 3;
    localparam int LB_PRX  = 4;
    localparam int LAT_N   = 5;
endpackage

// File: rtl/phy_ctrl_reg.sv
// Control and advertisement registers.
// Holds the mode bits, locks speed/duplex while auto-negotiation is enabled,
// and emits a one-cycle restart strobe. A synchronous clear (soft reset) behaves like reset.
module phy_ctrl_reg
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              wr_ctrl,
    input  logic              wr_adv,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic              restart_pulse,
    output logic [DATA_W-1:0] adv,
    output logic [DATA_W-1:0] ctrl_view
);
    // Mode bits: speed and duplex only follow writes while negotiation is off.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            ctrl <= CTRL_RST;
        end else if (wr_ctrl) begin
            ctrl.loopback   <= wdata[CB_LOOP];
            ctrl.aneg_en    <= wdata[CB_ANEG];
            ctrl.power_down <= wdata[CB_PWRDN];
            ctrl.coll_test  <= wdata[CB_COLT];
            if (!ctrl.aneg_en) begin
                ctrl.speed_100   <= wdata[CB_SPEED];
                ctrl.full_duplex <= wdata[CB_DUPLEX];
            end
        end
    end

    // Restart command: never stored, only strobed for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) restart_pulse <= 1'b0;
        else                    restart_pulse <= wr_ctrl && wdata[CB_RESTART];
    end

    // Advertisement word: only the masked bits take write data.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) adv <= ADV_RST;
        else if (wr_adv)        adv <= (adv & ~ADV_WMASK) | (wdata & ADV_WMASK);
    end

    // Readback image of the control register; command bits read zero.
    always_comb begin
        ctrl_view             = '0;
        ctrl_view[CB_LOOP]    = ctrl.loopback;
        ctrl_view[CB_SPEED]   = ctrl.speed_100;
        ctrl_view[CB_ANEG]    = ctrl.aneg_en;
        ctrl_view[CB_PWRDN]   = ctrl.power_down;
        ctrl_view[CB_DUPLEX]  = ctrl.full_duplex;
        ctrl_view[CB_COLT]    = ctrl.coll_test;
    end
endmodule

// File: rtl/phy_latch_bits.sv
// Vector of clear-on-read latching status bits.
// Each bit latches high or latches low, chosen per bit by LOW_MASK. A read
// reloads the bit from the current input, so an event in the read cycle stays latched.
module phy_latch_bits #(
    parameter int            N        = 5,
    parameter logic [N-1:0]  LOW_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] rd_clr,
    output logic [N-1:0] lat
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (LOW_MASK[i]) begin : g_low
            // Latch-low: any low input sticks until the register is read.
            always_ff @(posedge clk) begin
                if (!rst_n || soft_clr) lat[i] <= 1'b0;
                else if (rd_clr[i])     lat[i] <= raw[i];
                else                    lat[i] <= lat[i] & raw[i];
            end
        end else begin : g_high
            // Latch-high: any high input sticks until the register is read.
            always_ff @(posedge clk) begin
                if (!rst_n || soft_clr) lat[i] <= 1'b0;
                else if (rd_clr[i])     lat[i] <= raw[i];
                else                    lat[i] <= lat[i] | raw[i];
            end
        end
    end
endmodule

// File: rtl/phy_irq_reg.sv
// Interrupt control/status register: edge detection of the raw conditions,
// clear-on-read event flags, writable enables and the combined interrupt line.
module phy_irq_reg
    import phy_mgmt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_clr,
    input  logic            link_up,
    input  logic            jabber,
    input  logic            rem_fault,
    input  logic            rx_err,
    input  logic            aneg_complete,
    input  logic            page_rcvd,
    input  logic            par_fault,
    input  logic            lp_ack,
    input  logic            wr_en,
    input  logic [EV_N-1:0] en_wdata,
    input  logic            rd_clr,
    output logic [EV_N-1:0] flags,
    output logic [EV_N-1:0] enables,
    output logic            irq
);
    logic prv_link, prv_jab, prv_rf, prv_rxer, prv_an;
    logic [EV_N-1:0] ev;

    // Previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            {prv_link, prv_jab, prv_rf, prv_rxer, prv_an} <= '0;
        end else begin
            {prv_link, prv_jab, prv_rf, prv_rxer, prv_an} <=
                {link_up, jabber, rem_fault, rx_err, aneg_complete};
        end
    end

    // Events in flag bit order 7..0.
    assign ev = {jabber & ~prv_jab, rx_err & ~prv_rxer, page_rcvd, par_fault,
                 lp_ack, link_up ^ prv_link, rem_fault & ~prv_rf, aneg_complete & ~prv_an};

    // Flags: accumulate events, reload with this cycle's events on a read.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) flags <= '0;
        else if (rd_clr)        flags <= ev;
        else                    flags <= flags | ev;
    end

    // Enables: plain writable byte.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) enables <= '0;
        else if (wr_en)         enables <= en_wdata;
    end

    assign irq = |(flags & enables);
endmodule

// File: rtl/phy_mgmt_regfile.sv
// PHY management register file top: address decode, read mux and response register.
// Assumes request fields are valid whenever mgmt_req is high; one request per cycle.
module phy_mgmt_regfile
    import phy_mgmt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PHY_ADDR = 5'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mgmt_req,
    input  logic              mgmt_we,
    input  logic [ADDR_W-1:0] mgmt_phy_addr,
    input  logic [ADDR_W-1:0] mgmt_reg_addr,
    input  logic [DATA_W-1:0] mgmt_wdata,
    output logic              mgmt_rvalid,
    output logic [DATA_W-1:0] mgmt_rdata,
    input  logic              link_up,
    input  logic              jabber,
    input  logic              rem_fault,
    input  logic              rx_err,
    input  logic              aneg_complete,
    input  logic              page_rcvd,
    input  logic              par_fault,
    input  logic              lp_ack,
    output logic              ctl_loopback,
    output logic              ctl_speed_100,
    output logic              ctl_aneg_en,
    output logic              ctl_power_down,
    output logic              ctl_full_duplex,
    output logic              ctl_coll_test,
    output logic              aneg_restart,
    output logic              phy_rst_pulse,
    output logic              irq
);
    logic hit, rd_hit, wr_hit, soft_clr;
    logic rd_stat, rd_exp, rd_irq;
    ctrl_t ctrl;
    logic [DATA_W-1:0] adv, ctrl_view, view;
    logic [LAT_N-1:0]  lat, lat_raw, lat_clr;
    logic [EV_N-1:0]   flags, enables;

    // Request decode.
    assign hit      = mgmt_req && (mgmt_phy_addr == PHY_ADDR);
    assign rd_hit   = hit && !mgmt_we;
    assign wr_hit   = hit && mgmt_we;
    assign soft_clr = wr_hit && (mgmt_reg_addr == REG_CTRL) && mgmt_wdata[CB_RESET];
    assign rd_stat  = rd_hit && (mgmt_reg_addr == REG_STAT);
    assign rd_exp   = rd_hit && (mgmt_reg_addr == REG_EXP);
    assign rd_irq   = rd_hit && (mgmt_reg_addr == REG_IRQ);

    phy_ctrl_reg i_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .wr_ctrl(wr_hit && (mgmt_reg_addr == REG_CTRL)),
        .wr_adv(wr_hit && (mgmt_reg_addr == REG_ADV)),
        .wdata(mgmt_wdata), .ctrl(ctrl), .restart_pulse(aneg_restart),
        .adv(adv), .ctrl_view(ctrl_view)
    );

    // Latch inputs and their clear-on-read sources.
    always_comb begin
        lat_raw          = '0;
        lat_raw[LB_LINK] = link_up;
        lat_raw[LB_JAB]  = jabber;
        lat_raw[LB_RF]   = rem_fault;
        lat_raw[LB_PDF]  = par_fault;
        lat_raw[LB_PRX]  = page_rcvd;
        lat_clr          = '0;
        lat_clr[LB_LINK] = rd_stat;
        lat_clr[LB_JAB]  = rd_stat;
        lat_clr[LB_RF]   = rd_stat;
        lat_clr[LB_PDF]  = rd_exp;
        lat_clr[LB_PRX]  = rd_exp;
    end

    phy_latch_bits #(.N(LAT_N), .LOW_MASK(LAT_N'(1) << LB_LINK)) i_lat (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .raw(lat_raw), .rd_clr(lat_clr), .lat(lat)
    );

    phy_irq_reg i_irq (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .link_up(link_up), .jabber(jabber), .rem_fault(rem_fault), .rx_err(rx_err),
        .aneg_complete(aneg_complete), .page_rcvd(page_rcvd), .par_fault(par_fault),
        .lp_ack(lp_ack), .wr_en(wr_hit && (mgmt_reg_addr == REG_IRQ)),
        .en_wdata(mgmt_wdata[DATA_W-1:DATA_W-EV_N]), .rd_clr(rd_irq),
        .flags(flags), .enables(enables), .irq(irq)
    );

    // Read multiplexer; unimplemented addresses give zero.
    always_comb begin
        view = '0;
        case (mgmt_reg_addr)
            REG_CTRL: view = ctrl_view;
            REG_STAT: view = ABILITY | {10'b0, aneg_complete, lat[LB_RF], ctrl.aneg_en,
                                        lat[LB_LINK], lat[LB_JAB], 1'b1};
            REG_ID1:  view = ID1_VAL;
            REG_ID2:  view = ID2_VAL;
            REG_ADV:  view = adv;
            REG_EXP:  view = {11'b0, lat[LB_PDF], 2'b0, lat[LB_PRX], 1'b0};
            REG_IRQ:  view = {enables, flags};
            default:  view = '0;
        endcase
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mgmt_rvalid <= 1'b0;
            mgmt_rdata  <= '0;
        end else begin
            mgmt_rvalid <= rd_hit;
            if (rd_hit) mgmt_rdata <= view;
        end
    end

    // Soft reset strobe toward the rest of the PHY.
    always_ff @(posedge clk) begin
        if (!rst_n) phy_rst_pulse <= 1'b0;
        else        phy_rst_pulse <= soft_clr;
    end

    assign ctl_loopback    = ctrl.loopback;
    assign ctl_speed_100   = ctrl.speed_100;
    assign ctl_aneg_en     = ctrl.aneg_en;
    assign ctl_power_down  = ctrl.power_down;
    assign ctl_full_duplex = ctrl.full_duplex;
    assign ctl_coll_test   = ctrl.coll_test;
endmodule

// File: rtl/phy_mgmt_checker.sv
// Property checker for the PHY management register file, bound to the top module.
// Assumes reset is held low for the first clock edges.
module phy_mgmt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mgmt_req,
    input logic        mgmt_we,
    input logic [4:0]  mgmt_phy_addr,
    input logic [4:0]  mgmt_reg_addr,
    input logic        wd_reset_bit,
    input logic        wd_restart_bit,
    input logic        mgmt_rvalid,
    input logic [15:0] mgmt_rdata,
    input logic        ctl_aneg_en,
    input logic        ctl_speed_100,
    input logic        ctl_full_duplex,
    input logic        aneg_restart,
    input logic        phy_rst_pulse
);
    logic ctrl_wr, known_reg;
    assign ctrl_wr   = mgmt_req && mgmt_we && (mgmt_phy_addr == 5'd1) && (mgmt_reg_addr == 5'd0);
    assign known_reg = (mgmt_reg_addr <= 5'd4) || (mgmt_reg_addr == 5'd6) || (mgmt_reg_addr == 5'd17);

    // A response follows only a read aimed at this PHY.
    assert_resp_only_own_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_rvalid |-> $past(mgmt_req && !mgmt_we && mgmt_phy_addr == 5'd1));

    // Unimplemented registers read zero.
    assert_unknown_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_rvalid && !$past(known_reg) |-> mgmt_rdata == 16'h0000);

    // Command bits of the control register never read back as 1.
    assert_cmd_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_rvalid && $past(mgmt_reg_addr == 5'd0) |-> !mgmt_rdata[15] && !mgmt_rdata[9]);

    // The restart strobe follows a control write carrying bit 9.
    assert_restart_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        aneg_restart |-> $past(ctrl_wr && wd_restart_bit && !wd_reset_bit));

    // The soft reset strobe follows a control write carrying bit 15.
    assert_softrst_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phy_rst_pulse |-> $past(ctrl_wr && wd_reset_bit));

    // Speed and duplex hold while negotiation was enabled (soft reset excepted).
    assert_mode_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_aneg_en) && !$past(ctrl_wr && wd_reset_bit) |->
            ctl_speed_100 == $past(ctl_speed_100) && ctl_full_duplex == $past(ctl_full_duplex));

    // Identifier registers are constant.
    assert_id_const_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_rvalid && $past(mgmt_reg_addr == 5'd2) |-> mgmt_rdata == 16'h000E);
endmodule

bind phy_mgmt_regfile phy_mgmt_checker i_chk (
    .clk(clk), .rst_n(rst_n), .mgmt_req(mgmt_req), .mgmt_we(mgmt_we),
    .mgmt_phy_addr(mgmt_phy_addr), .mgmt_reg_addr(mgmt_reg_addr),
    .wd_reset_bit(mgmt_wdata[15]), .wd_restart_bit(mgmt_wdata[9]),
    .mgmt_rvalid(mgmt_rvalid), .mgmt_rdata(mgmt_rdata),
    .ctl_aneg_en(ctl_aneg_en), .ctl_speed_100(ctl_speed_100),
    .ctl_full_duplex(ctl_full_duplex), .aneg_restart(aneg_restart),
    .phy_rst_pulse(phy_rst_pulse)
);

// File: tb/test_phy_mgmt_regfile.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every cycle, plus directed checks.
module test_phy_mgmt_regfile;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mgmt_req = 0, mgmt_we = 0;
    logic [4:0] mgmt_phy_addr = 0, mgmt_reg_addr = 0;
    logic [15:0] mgmt_wdata = 0;
    logic link_up = 0, jabber = 0, rem_fault = 0, rx_err = 0, aneg_complete = 0;
    logic page_rcvd = 0, par_fault = 0, lp_ack = 0;
    logic mgmt_rvalid, ctl_loopback, ctl_speed_100, ctl_aneg_en, ctl_power_down;
    logic ctl_full_duplex, ctl_coll_test, aneg_restart, phy_rst_pulse, irq;
    logic [15:0] mgmt_rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    phy_mgmt_regfile i_phy_mgmt_regfile (.*);

    // ---------------- reference model ----------------
    bit m_live = 0;
    bit m_lb, m_spd, m_an, m_pd, m_dup, m_colt, m_rst_p, m_rs_p, m_rvalid;
    bit m_link, m_jab, m_rf, m_pdf, m_prx;
    bit p_link, p_jab, p_rf, p_rxer, p_an;
    logic [15:0] m_adv, m_rdata;
    logic [7:0]  m_en, m_fl, m_ev;
    bit hit_rd, hit_wr, swr;

    function automatic logic [15:0] m_view(input logic [4:0] a);
        case (a)
            5'd0:  return {1'b0, m_lb, m_spd, m_an, m_pd, 2'b00, m_dup, m_colt, 7'b0};
            5'd1:  return 16'h7800 | {10'b0, aneg_complete, m_rf, m_an, m_link, m_jab, 1'b1};
            5'd2:  return 16'h000E;
            5'd3:  return 16'h7237;
            5'd4:  return m_adv;
            5'd6:  return {11'b0, m_pdf, 2'b0, m_prx, 1'b0};
            5'd17: return {m_en, m_fl};
            default: return 16'h0;
        endcase
    endfunction

    task automatic m_clear();
        {m_lb, m_pd, m_colt} = '0; {m_spd, m_an, m_dup} = 3'b111;
        m_adv = 16'h01E1; m_rs_p = 0;
        {m_link, m_jab, m_rf, m_pdf, m_prx} = '0;
        {p_link, p_jab, p_rf, p_rxer, p_an} = '0;
        m_en = 0; m_fl = 0;
    endtask

    always @(posedge clk) begin
        hit_rd = mgmt_req && !mgmt_we && mgmt_phy_addr == 5'd1;
        hit_wr = mgmt_req && mgmt_we && mgmt_phy_addr == 5'd1;
        swr = hit_wr && mgmt_reg_addr == 5'd0 && mgmt_wdata[15];
        m_live = 1;
        if (!rst_n) begin
            m_clear(); m_rvalid = 0; m_rdata = 0; m_rst_p = 0;
        end else if (swr) begin
            m_clear(); m_rvalid = 0; m_rst_p = 1;
        end else begin
            m_rst_p = 0;
            m_rvalid = hit_rd;
            if (hit_rd) m_rdata = m_view(mgmt_reg_addr);
            m_ev = {jabber & ~p_jab, rx_err & ~p_rxer, page_rcvd, par_fault, lp_ack,
                    link_up ^ p_link, rem_fault & ~p_rf, aneg_complete & ~p_an};
            m_fl = (hit_rd && mgmt_reg_addr == 5'd17) ? m_ev : (m_fl | m_ev);
            if (hit_rd && mgmt_reg_addr == 5'd1) begin
                m_link = link_up; m_jab = jabber; m_rf = rem_fault;
            end else begin
                m_link = m_link && link_up; m_jab = m_jab || jabber; m_rf = m_rf || rem_fault;
            end
            if (hit_rd && mgmt_reg_addr == 5'd6) begin
                m_pdf = par_fault; m_prx = page_rcvd;
            end else begin
                m_pdf = m_pdf || par_fault; m_prx = m_prx || page_rcvd;
            end
            p_link = link_up; p_jab = jabber; p_rf = rem_fault; p_rxer = rx_err; p_an = aneg_complete;
            m_rs_p = hit_wr && mgmt_reg_addr == 5'd0 && mgmt_wdata[9];
            if (hit_wr && mgmt_reg_addr == 5'd0) begin
                if (!m_an) begin m_spd = mgmt_wdata[13]; m_dup = mgmt_wdata[8]; end
                m_lb = mgmt_wdata[14]; m_an = mgmt_wdata[12];
                m_pd = mgmt_wdata[11]; m_colt = mgmt_wdata[7];
            end
            if (hit_wr && mgmt_reg_addr == 5'd4)
                m_adv = (m_adv & ~16'h2DE0) | (mgmt_wdata & 16'h2DE0);
            if (hit_wr && mgmt_reg_addr == 5'd17) m_en = mgmt_wdata[15:8];
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (m_live) begin
            check("R2 rvalid", 16'(mgmt_rvalid), 16'(m_rvalid));
            if (m_rvalid) check("R2 rdata", mgmt_rdata, m_rdata);
            check("R3 R5 mode", 16'({ctl_loopback, ctl_speed_100, ctl_aneg_en, ctl_power_down,
                                      ctl_full_duplex, ctl_coll_test}),
                  16'({m_lb, m_spd, m_an, m_pd, m_dup, m_colt}));
            check("R3 restart", 16'(aneg_restart), 16'(m_rs_p));
            check("R4 reset strobe", 16'(phy_rst_pulse), 16'(m_rst_p));
            check("R11 irq", 16'(irq), 16'(|(m_fl & m_en)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
        @(negedge clk);
        mgmt_req = 1; mgmt_we = 1; mgmt_phy_addr = phy; mgmt_reg_addr = ra; mgmt_wdata = d;
        @(negedge clk);
        mgmt_req = 0; mgmt_we = 0;
    endtask

    task automatic rd(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] exp,
                      input logic [15:0] mask, input string tag);
        @(negedge clk);
        mgmt_req = 1; mgmt_we = 0; mgmt_phy_addr = phy; mgmt_reg_addr = ra;
        @(negedge clk);
        mgmt_req = 0;
        check(tag, 16'(mgmt_rvalid), 16'(phy == 5'd1));
        if (phy == 5'd1) check(tag, mgmt_rdata & mask, exp & mask);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R3 reset state
        check("R3 reset speed/aneg/duplex", 16'({ctl_speed_100, ctl_aneg_en, ctl_full_duplex}), 16'h7);
        check("R11 irq at reset", 16'(irq), 16'h0);
        rd(5'd1, 5'd0, 16'h3100, 16'hFFFF, "R3 control reset");
        rd(5'd1, 5'd2, 16'h000E, 16'hFFFF, "R6 id1");
        rd(5'd1, 5'd3, 16'h7237, 16'hFFFF, "R6 id2");
        rd(5'd1, 5'd4, 16'h01E1, 16'hFFFF, "R6 adv reset");
        rd(5'd1, 5'd9, 16'h0000, 16'hFFFF, "R2 unsupported");
        rd(5'd1, 5'd5, 16'h0000, 16'hFFFF, "R2 unsupported 5");
        // R1 foreign PHY address
        rd(5'd2, 5'd0, 16'h0000, 16'h0000, "R1 no response");
        wr(5'd3, 5'd0, 16'h0000);
        rd(5'd1, 5'd0, 16'h3100, 16'hFFFF, "R1 write ignored");
        // R5 lock while negotiation enabled
        wr(5'd1, 5'd0, 16'h0000);
        rd(5'd1, 5'd0, 16'h2100, 16'hFFFF, "R5 locked bits kept");
        wr(5'd1, 5'd0, 16'h0000);
        rd(5'd1, 5'd0, 16'h0000, 16'hFFFF, "R5 forced mode");
        check("R5 speed output", 16'(ctl_speed_100), 16'h0);
        wr(5'd1, 5'd0, 16'h3100);
        // R3 restart strobe and writable bits
        @(negedge clk);
        mgmt_req = 1; mgmt_we = 1; mgmt_phy_addr = 5'd1; mgmt_reg_addr = 5'd0; mgmt_wdata = 16'h5A80;
        @(negedge clk);
        mgmt_req = 0; mgmt_we = 0;
        check("R3 restart strobe", 16'(aneg_restart), 16'h1);
        @(negedge clk);
        check("R3 strobe one cycle", 16'(aneg_restart), 16'h0);
        rd(5'd1, 5'd0, 16'h7980, 16'hFFFF, "R3 writable bits");
        wr(5'd1, 5'd0, 16'h3100);
        // R7 latch-low link
        link_up = 1; idle(1);
        rd(5'd1, 5'd1, 16'h7809, 16'hFFFF, "R7 link latched low");
        rd(5'd1, 5'd1, 16'h780D, 16'hFFFF, "R7 link up after read");
        link_up = 0; idle(1); link_up = 1; idle(1);
        rd(5'd1, 5'd1, 16'h7809, 16'hFFFF, "R7 link drop held");
        rd(5'd1, 5'd1, 16'h780D, 16'hFFFF, "R7 link recovered");
        // R8 latch-high jabber and remote fault
        jabber = 1; idle(1); jabber = 0; idle(1);
        rd(5'd1, 5'd1, 16'h780F, 16'hFFFF, "R8 jabber latched");
        rem_fault = 1; idle(1); rem_fault = 0; idle(1);
        rd(5'd1, 5'd1, 16'h781D, 16'hFFFF, "R8 fault latched, jabber cleared");
        rd(5'd1, 5'd1, 16'h780D, 16'hFFFF, "R8 cleared by read");
        // R9 expansion
        par_fault = 1; page_rcvd = 1; idle(1); par_fault = 0; page_rcvd = 0; idle(1);
        rd(5'd1, 5'd6, 16'h0012, 16'hFFFF, "R9 expansion latched");
        rd(5'd1, 5'd6, 16'h0000, 16'hFFFF, "R9 expansion cleared");
        // R10 / R11 interrupt flags and enables
        rd(5'd1, 5'd17, 16'h0000, 16'h0000, "R10 clear flags");
        wr(5'd1, 5'd17, 16'h0400);
        check("R11 irq no flag", 16'(irq), 16'h0);
        rx_err = 1; idle(2); rx_err = 0; idle(1);
        check("R11 masked flag", 16'(irq), 16'h0);
        rd(5'd1, 5'd17, 16'h0440, 16'hFFFF, "R10 rx error flag");
        link_up = 0; idle(1);
        check("R11 irq on enabled flag", 16'(irq), 16'h1);
        rd(5'd1, 5'd17, 16'h0404, 16'hFFFF, "R10 link change flag");
        check("R10 flags cleared irq", 16'(irq), 16'h0);
        // R12 event during read
        rd(5'd1, 5'd1, 16'h0000, 16'h0000, "R12 clear status");
        @(negedge clk);
        mgmt_req = 1; mgmt_we = 0; mgmt_phy_addr = 5'd1; mgmt_reg_addr = 5'd1; jabber = 1;
        @(negedge clk);
        mgmt_req = 0; jabber = 0;
        check("R12 pre-event value", 16'(mgmt_rdata[1]), 16'h0);
        rd(5'd1, 5'd1, 16'h0002, 16'h0002, "R12 event kept");
        // R4 soft reset
        wr(5'd1, 5'd4, 16'h0000);
        rd(5'd1, 5'd4, 16'h0001, 16'hFFFF, "R6 adv write mask");
        wr(5'd1, 5'd17, 16'hFF00);
        @(negedge clk);
        mgmt_req = 1; mgmt_we = 1; mgmt_phy_addr = 5'd1; mgmt_reg_addr = 5'd0; mgmt_wdata = 16'h8000;
        @(negedge clk);
        mgmt_req = 0; mgmt_we = 0;
        check("R4 reset strobe", 16'(phy_rst_pulse), 16'h1);
        rd(5'd1, 5'd0, 16'h3100, 16'hFFFF, "R4 control restored");
        rd(5'd1, 5'd4, 16'h01E1, 16'hFFFF, "R4 adv restored");
        rd(5'd1, 5'd17, 16'h0000, 16'hFFFF, "R4 irq reg restored");
        idle(2);
        finish_run();
    end
endmodule